// File: doc/BRIEF.md
# Serial Peripheral Master Controller

This block is a single-channel master for a four-wire serial peripheral bus. Software reaches it through a small 16-bit register bus with three registers: data, control and status. A write to the data register, made while the block is enabled and idle, starts a full-duplex shift of one 8-bit or 16-bit word. The serial clock comes from the system clock through a programmable divider, and all four polarity and phase combinations are available. When the shift completes, the received word is latched into a one-word receive buffer and a buffer-full flag is raised. A level interrupt reports a full receive buffer, a transmitter that is ready, or both.

The bus has no back-pressure. A write to the data register while a word is shifting, or while the block is disabled, is dropped, so software polls the busy flag or waits for the ready interrupt before it writes. The receive buffer holds one word and never stalls the shifter: a word that completes before the previous one is read replaces it. Chip selects are general-purpose outputs outside this block.

Top module: `spim_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, SCLK is low and the interrupt is low.
- R2: Control register (address 2) layout: bit 0 enable, bit 2 word size (0 = 8 bits, 1 = 16 bits), bit 5 receive-full interrupt enable, bit 6 transmit-ready interrupt enable, bit 7 polarity, bit 8 phase, bits 15:9 divider N. Bits 1, 3 and 4 always read 0.
- R3: A write to the data register (address 0) starts a transfer only when enable is set and the block is not busy. Otherwise the write has no effect on the shift in progress or on the status.
- R4: During a transfer SCLK toggles every N+1 system clocks, making 2×W edges for a W-bit word. Busy lasts exactly 2×W×(N+1) cycles after the write.
- R5: The control bits are mapped crosswise to the SPI modes: bit 7 alone gives mode 2 (SCLK idles high), bit 8 alone gives mode 1 (data changes on the leading edge and is sampled on the trailing edge), and both bits give mode 3. With phase 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. When no transfer runs, SCLK stays at the polarity level.
- R6: Data moves MSB first. In 8-bit mode only the low byte of the written word is sent, and the received word reads back with its upper byte zero.
- R7: Completion sets receive-full. A read of the data register returns the buffer and clears the flag. A word that completes before the read overwrites the buffer.
- R8: Status register (address 4): bit 0 busy, bit 1 receive-full, all other bits 0.
- R9: A control write that clears enable aborts the shift at once: busy clears, SCLK returns to its idle level, and the written control value is retained.
- R10: irq = (receive-full AND bit 5) OR (not busy AND enable AND bit 6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte address (0 data, 2 control, 4 status) |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; a data read clears receive-full |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus carries at most one access per cycle and never a read and a write together. They also assume that the control register is rewritten during a shift only to clear enable, because the divider and the edge counters expect N and the word size to stay constant while a word is moving. The stimulus follows these rules: control writes happen only while the model reports the block idle, except for the deliberate abort, and data reads come only after the model has seen the transfer finish. Reads and aborts therefore never fall in the same cycle as a completion.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W  = 16;
  localparam int DIV_W   = 7;
  localparam int ADDR_W  = 3;
  localparam int NARROW  = WORD_W / 2;
  localparam int HALF_W  = $clog2(2 * WORD_W);

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  localparam logic [WORD_W-1:0] CTRL_WMASK = 16'hFFE5;

  typedef struct packed {
    logic [DIV_W-1:0] div_n;
    logic             phase;
    logic             idle_hi;
    logic             ie_tx;
    logic             ie_rx;
    logic [1:0]       rsv_b;
    logic             wide;
    logic             rsv_a;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || !run || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (cnt <= limit)); // R4
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              wide,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  input  logic [WORD_W-1:0] tx_word,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int NARROW = WORD_W / 2;
  localparam int HALF_W = $clog2(2 * WORD_W);
  localparam logic [HALF_W-1:0] LAST_WIDE   = HALF_W'(2 * WORD_W - 1);
  localparam logic [HALF_W-1:0] LAST_NARROW = HALF_W'(WORD_W - 1);

  logic [WORD_W-1:0] tx_sr, rx_sr, rx_next, tx_load;
  logic [HALF_W-1:0] hcnt, last_edge;
  logic              sclk_q, edge_even, do_sample, do_shift;

  assign last_edge = wide ? LAST_WIDE : LAST_NARROW;
  assign edge_even = ~hcnt[0];
  assign do_sample = cpha ? ~edge_even : edge_even;
  assign do_shift  = cpha ? (edge_even && (hcnt != '0)) : ~edge_even;
  assign rx_next   = do_sample ? {rx_sr[WORD_W-2:0], miso} : rx_sr;
  assign tx_load   = wide ? tx_word : {tx_word[NARROW-1:0], {NARROW{1'b0}}};
  assign rx_word   = wide ? rx_next : {{NARROW{1'b0}}, rx_next[NARROW-1:0]};
  assign done      = busy && tick && (hcnt == last_edge);
  assign mosi      = tx_sr[WORD_W-1];
  assign sclk      = busy ? sclk_q : cpol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      hcnt   <= '0;
      sclk_q <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      hcnt   <= '0;
      sclk_q <= cpol;
      tx_sr  <= tx_load;
      rx_sr  <= '0;
    end else if (busy && tick) begin
      sclk_q <= ~sclk_q;
      hcnt   <= hcnt + 1'b1;
      rx_sr  <= rx_next;
      if (do_shift) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      if (hcnt == last_edge) busy <= 1'b0;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R3
  AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hcnt <= last_edge)); // R4
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] rx_buf, rx_word;
  logic              rx_full, busy, done, tick;
  logic              wr_ctrl, wr_data, rd_data, start, abort;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);
  assign start   = wr_data && ctrl_q.en && !busy;
  assign abort   = wr_ctrl && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata & CTRL_WMASK);
      if (done) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = rx_buf;
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: bus_rdata = {{(WORD_W-2){1'b0}}, rx_full, busy};
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = (rx_full && ctrl_q.ie_rx) || (!busy && ctrl_q.en && ctrl_q.ie_tx);

  spim_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start),
    .limit(ctrl_q.div_n), .tick(tick)
  );

  spim_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .wide(ctrl_q.wide), .cpol(ctrl_q.idle_hi), .cpha(ctrl_q.phase),
    .tick(tick), .miso(spi_miso), .tx_word(bus_wdata),
    .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi), .done(done),
    .rx_word(rx_word)
  );

  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rx_full); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R9
  AST_IDLE_SCLK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(ctrl_q)) |-> $stable(spi_sclk)); // R5
endmodule

// File: tb/spim_top_test.sv
module spim_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        spi_sclk, spi_mosi, irq;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;
  bit run_cmp = 0;

  spim_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_ctrl = '0;
  bit m_busy = 0, m_full = 0, m_fin, m_pre_busy, m_pre_en;
  int m_c = 0, m_bits = 8, m_div = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_busy = 0; m_c = 0; m_full = 0;
    end else begin
      m_pre_busy = m_busy; m_pre_en = m_ctrl[0]; m_fin = 0;
      if (m_busy) begin
        m_c++;
        if (m_c == m_bits * 2 * (m_div + 1)) begin m_busy = 0; m_fin = 1; end
      end
      if (bus_wr && bus_addr == 3'd2) begin
        m_ctrl = bus_wdata & 16'hFFE5;
        if (!bus_wdata[0]) m_busy = 0;
      end
      if (bus_wr && bus_addr == 3'd0 && m_pre_en && !m_pre_busy) begin
        m_busy = 1; m_c = 0;
        m_bits = m_ctrl[2] ? 16 : 8;
        m_div = int'(m_ctrl[15:9]);
      end
      if (m_fin) m_full = 1;
      else if (bus_rd && bus_addr == 3'd0) m_full = 0;
    end
  end

  function automatic logic exp_sclk();
    if (m_busy) return m_ctrl[7] ^ logic'((m_c / (m_div + 1)) % 2);
    return m_ctrl[7];
  endfunction

  function automatic logic exp_irq();
    return (m_full && m_ctrl[5]) || (!m_busy && m_ctrl[0] && m_ctrl[6]);
  endfunction

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R4 sclk", int'(spi_sclk), int'(exp_sclk()));
      chk("R10 irq", int'(irq), int'(exp_irq()));
    end
  end

  // slave device model
  bit s_act = 0, s_cpol = 0, s_cpha = 0;
  int s_w = 8, s_idx = 0;
  logic [15:0] s_word = '0, s_cap = '0;

  function automatic logic sbit(int i);
    return (i < s_w) ? s_word[s_w-1-i] : 1'b0;
  endfunction

  always @(spi_sclk) begin
    if (s_act) begin
      if (!s_cpha) begin
        if (spi_sclk != s_cpol) s_cap = {s_cap[14:0], spi_mosi};
        else begin s_idx++; spi_miso = sbit(s_idx); end
      end else begin
        if (spi_sclk != s_cpol) begin spi_miso = sbit(s_idx); s_idx++; end
        else s_cap = {s_cap[14:0], spi_mosi};
      end
    end
  end

  task automatic bus_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] mk_ctrl(int mode, bit wide, int div, bit ie_rx, bit ie_tx);
    logic [15:0] v = 16'h0001;
    v[2] = wide; v[5] = ie_rx; v[6] = ie_tx;
    v[7] = (mode >= 2);
    v[8] = (mode == 1 || mode == 3);
    v[15:9] = 7'(div);
    return v;
  endfunction

  task automatic start_xfer(logic [15:0] ctrl, logic [15:0] tx, logic [15:0] sw);
    bus_write(3'd2, ctrl);
    s_cpol = ctrl[7]; s_cpha = ctrl[8]; s_w = ctrl[2] ? 16 : 8;
    s_word = sw; s_idx = 0; s_cap = '0;
    spi_miso = s_cpha ? 1'b0 : sbit(0);
    s_act = 1;
    bus_write(3'd0, tx);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    s_act = 0;
  endtask

  task automatic full_xfer(int mode, bit wide, int div, logic [15:0] tx,
                           logic [15:0] sw, bit poke);
    logic [15:0] d, mask;
    mask = wide ? 16'hFFFF : 16'h00FF;
    start_xfer(mk_ctrl(mode, wide, div, 1'b1, 1'b0), tx, sw);
    if (poke) begin
      repeat (5) @(negedge clk);
      bus_write(3'd0, ~tx);
      bus_read(3'd4, d);
      chk("R3 busy kept on write while busy", int'(d), 1);
    end
    wait_idle();
    chk("R7 irq on full", int'(irq), 1);
    bus_read(3'd4, d);
    chk("R8 status after completion", int'(d), 2);
    bus_read(3'd0, d);
    chk("R6 received word", int'(d), int'(sw & mask));
    chk("R5 slave captured MOSI", int'(s_cap & mask), int'(tx & mask));
    bus_read(3'd4, d);
    chk("R7 read clears full", int'(d), 0);
  endtask

  initial begin
    logic [15:0] d, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1;
    // R1
    bus_read(3'd2, d); chk("R1 ctrl reset", int'(d), 0);
    bus_read(3'd4, d); chk("R1 status reset", int'(d), 0);
    chk("R1 sclk reset", int'(spi_sclk), 0);
    chk("R1 irq reset", int'(irq), 0);
    // R2
    bus_write(3'd2, 16'hFFFE);
    bus_read(3'd2, d); chk("R2 ctrl readback", int'(d), 16'hFFE4);
    chk("R5 idle high sclk", int'(spi_sclk), 1);
    // R3 disabled write ignored
    bus_write(3'd2, 16'h0040);
    bus_write(3'd0, 16'h1234);
    bus_read(3'd4, d); chk("R3 disabled write ignored", int'(d), 0);
    chk("R3 no sclk activity", int'(spi_sclk), 0);
    // transfers over modes, sizes and divisors
    full_xfer(0, 1'b0, 1, 16'h00A5, 16'h003C, 1'b0);
    full_xfer(1, 1'b1, 2, 16'hC3E1, 16'h5A96, 1'b0);
    full_xfer(2, 1'b0, 0, 16'h7F81, 16'h00D2, 1'b0);
    full_xfer(3, 1'b1, 1, 16'h8001, 16'hF00F, 1'b1);
    full_xfer(0, 1'b1, 3, 16'h1357, 16'hACE0, 1'b0);
    full_xfer(2, 1'b1, 1, 16'hBEEF, 16'h4321, 1'b0);
    // R7 overwrite
    start_xfer(mk_ctrl(1, 1'b0, 1, 1'b0, 1'b1), 16'h0011, 16'h0022);
    wait_idle();
    chk("R10 tx-ready irq", int'(irq), 1);
    start_xfer(mk_ctrl(1, 1'b0, 1, 1'b0, 1'b1), 16'h0033, 16'h0044);
    wait_idle();
    bus_read(3'd0, d); chk("R7 overwrite keeps newest", int'(d), 16'h0044);
    // R9 abort
    c = mk_ctrl(3, 1'b1, 127, 1'b0, 1'b1);
    start_xfer(c, 16'hFFFF, 16'h0000);
    repeat (300) @(negedge clk);
    bus_read(3'd4, d); chk("R4 busy mid transfer", int'(d), 1);
    s_act = 0;
    bus_write(3'd2, c & 16'hFFFE);
    bus_read(3'd4, d); chk("R9 abort clears busy", int'(d), 0);
    chk("R9 sclk idle after abort", int'(spi_sclk), 1);
    bus_read(3'd2, d); chk("R9 ctrl retained", int'(d), int'(c & 16'hFFFE));
    repeat (20) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule